// File: doc/BRIEF.md
# Bus-Master Disk DMA Control Register Block

This block is the software-facing register file of one bus-master disk DMA channel. Software reaches it over a small register bus that carries byte or dword accesses across eight byte offsets. The block holds three registers:

- a command byte, which starts or aborts a transfer and selects its direction;
- a status byte, which combines the engine's live activity, two event flags that are cleared by writing 1, and two per-drive capability flags owned by software;
- a 32-bit pointer to the descriptor table, aligned to a dword.

The block presents the run request, the direction and the table base to the DMA engine. It gathers the engine's busy level, the engine's error pulses and the drive interrupt line into the status byte. It also flags the single status pattern that marks a transfer as finished cleanly.

In normal use, software loads the table pointer and the direction, clears stale events by writing 1 to them, and then sets the run bit. When the drive interrupt arrives, software clears the run bit and checks the status byte to judge the result.

Top module: `bmdma_ctrl_regs`

## Requirements
- R1: After reset, start_o, to_mem_o, table_base_o, rsp_rdata_o and xfer_good_o are 0. The status byte reads 0 apart from bit 0, which follows eng_busy_i.
- R2: Command byte at offset 0. A write loads bit 0 into start_o and bit 3 into to_mem_o (1 = engine writes memory) on the next cycle. A read returns only bits 0 and 3; all other bits read 0.
- R3: Writing 0 to command bit 0 while a transfer runs drops start_o on the next cycle. Cycles without a command write leave start_o unchanged.
- R4: Status byte at offset 2. Bit 0 reads the current eng_busy_i level. Writes to bit 0 have no effect.
- R5: Status bit 1 is set one cycle after an eng_err_i pulse. Writing 1 to bit 1 clears it and writing 0 leaves it. If a set and a clear land in the same cycle, the set wins.
- R6: Status bit 2 is set on a 0-to-1 transition of drv_irq_i, and writing 1 to it clears it. A drv_irq_i level held high does not set it again; if a set and a clear land in the same cycle, the set wins.
- R7: Status bits 5 and 6 are plain read/write flags for drive 0 and drive 1. Status bits 3, 4 and 7 read 0.
- R8: The table pointer occupies offsets 4 to 7, little-endian. An aligned dword write loads the whole pointer, and a byte write loads one byte. Pointer bits 1:0 always read 0.
- R9: Offsets 1 and 3 read 0, and writes to them change no register.
- R10: xfer_good_o is 1 exactly when status bits 2:0 equal 100b: engine idle, no error, interrupt pending.
- R11: Read data appears on rsp_rdata_o in the cycle after the request. A byte read returns the byte in bits 7:0 with the upper bits 0. A dword read at offset 0 or 4 returns the four bytes little-endian. A dword access at an unaligned offset reads 0 and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Register access request, one cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_dword_i | input | 1 | 1 = dword access, 0 = byte access |
| req_addr_i | input | 3 | Byte offset |
| req_wdata_i | input | 32 | Write data; byte writes use bits 7:0 |
| rsp_rdata_o | output | 32 | Read data, registered |
| eng_busy_i | input | 1 | Engine active level |
| eng_err_i | input | 1 | Engine error pulse |
| drv_irq_i | input | 1 | Drive interrupt line |
| start_o | output | 1 | Run request to engine |
| to_mem_o | output | 1 | Direction, 1 = engine writes memory |
| table_base_o | output | 32 | Descriptor table base address |
| xfer_good_o | output | 1 | Status shows clean completion |

## Verification
The assertions assume the following about the block's inputs:

- eng_err_i and drv_irq_i are synchronous to clk_i.
- At most one register request is presented per cycle.
- Write data is stable for the cycle in which it is presented.

The bench holds to these assumptions by driving every input only on the falling edge and by keeping each request to a single cycle. It raises the interrupt line only after holding it low for at least one cycle, so each rising edge is seen once. It also places error pulses in the same cycle as clearing writes only where the set-wins rule is the subject of the test.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;
  localparam int unsigned OFS_CMD  = 0;
  localparam int unsigned OFS_STAT = 2;
  localparam int unsigned OFS_PTR  = 4;

  localparam int unsigned CMD_RUN   = 0;
  localparam int unsigned CMD_TOMEM = 3;

  localparam int unsigned ST_ACT  = 0;
  localparam int unsigned ST_ERR  = 1;
  localparam int unsigned ST_IRQ  = 2;
  localparam int unsigned ST_CAP0 = 5;
  localparam int unsigned ST_CAP1 = 6;

  typedef struct packed {
    logic run;
    logic to_mem;
  } cmd_t;
endpackage

// File: rtl/bmdma_cmd_reg.sv
module bmdma_cmd_reg
  import bmdma_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output logic       run_o,
  output logic       to_mem_o,
  output logic [7:0] rd_byte_o
);
  cmd_t cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= '0;
    end else if (wr_i) begin
      cmd_q.run    <= wdata_i[CMD_RUN];
      cmd_q.to_mem <= wdata_i[CMD_TOMEM];
    end
  end

  assign run_o    = cmd_q.run;
  assign to_mem_o = cmd_q.to_mem;

  always_comb begin
    rd_byte_o            = '0;
    rd_byte_o[CMD_RUN]   = cmd_q.run;
    rd_byte_o[CMD_TOMEM] = cmd_q.to_mem;
  end

  // R2: command write lands on the outputs next cycle
  a_r2_cmd_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (run_o == $past(wdata_i[CMD_RUN])) && (to_mem_o == $past(wdata_i[CMD_TOMEM])));
  // R3: run is only changed by a command write
  a_r3_run_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(run_o));
endmodule

// File: rtl/bmdma_stat_reg.sv
module bmdma_stat_reg
  import bmdma_regs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  input  logic       busy_i,
  input  logic       err_pulse_i,
  input  logic       irq_line_i,
  output logic [7:0] rd_byte_o,
  output logic       good_o
);
  logic       err_q, irq_q, irq_prev_q;
  logic [1:0] cap_q;
  logic       irq_edge, err_clr, irq_clr;

  assign irq_edge = irq_line_i & ~irq_prev_q;
  assign err_clr  = wr_i & wdata_i[ST_ERR];
  assign irq_clr  = wr_i & wdata_i[ST_IRQ];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      irq_prev_q <= 1'b0;
      cap_q      <= '0;
    end else begin
      irq_prev_q <= irq_line_i;
      // set has priority over write-1 clear
      if (err_pulse_i)  err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
      if (irq_edge)     irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
      if (wr_i)         cap_q <= {wdata_i[ST_CAP1], wdata_i[ST_CAP0]};
    end
  end

  always_comb begin
    rd_byte_o          = '0;
    rd_byte_o[ST_ACT]  = busy_i;
    rd_byte_o[ST_ERR]  = err_q;
    rd_byte_o[ST_IRQ]  = irq_q;
    rd_byte_o[ST_CAP0] = cap_q[0];
    rd_byte_o[ST_CAP1] = cap_q[1];
  end

  assign good_o = ~busy_i & ~err_q & irq_q;

  // R5: error pulse always registers
  a_r5_err_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_pulse_i |=> rd_byte_o[ST_ERR]);
  // R5: write-1 clears when no pulse competes
  a_r5_err_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[ST_ERR] && !err_pulse_i) |=> !rd_byte_o[ST_ERR]);
  // R6: rising interrupt line sets the pending flag
  a_r6_irq_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_line_i) |=> rd_byte_o[ST_IRQ]);
  // R6: a pending flag is never set without a line edge since the last sample
  a_r6_irq_no_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_byte_o[ST_IRQ] && irq_line_i) |=> (!rd_byte_o[ST_IRQ] || !$past(irq_prev_q)));
  // R7: capability flags follow a status write
  a_r7_cap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> rd_byte_o[ST_CAP1:ST_CAP0] == $past(wdata_i[ST_CAP1:ST_CAP0]));
endmodule

// File: rtl/bmdma_ptr_reg.sv
module bmdma_ptr_reg #(
  parameter int unsigned PTR_W     = 32,
  parameter int unsigned PTR_ALIGN = 2,
  localparam int unsigned LANES    = PTR_W / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] wr_be_i,
  input  logic [PTR_W-1:0] wdata_i,
  output logic [PTR_W-1:0] base_o
);
  localparam logic [PTR_W-1:0] KEEP_MASK = ~((PTR_W'(1) << PTR_ALIGN) - PTR_W'(1));

  logic [PTR_W-1:0] base_q;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q[8*b +: 8] <= '0;
      end else if (wr_be_i[b]) begin
        base_q[8*b +: 8] <= wdata_i[8*b +: 8] & KEEP_MASK[8*b +: 8];
      end
    end
  end

  assign base_o = base_q;

  // R8: full write loads the pointer, alignment bits stay clear
  a_r8_ptr_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&wr_be_i) |=> (base_o[PTR_W-1:PTR_ALIGN] == $past(wdata_i[PTR_W-1:PTR_ALIGN]))
                   && (base_o[PTR_ALIGN-1:0] == '0));
  // R8: no enable, no change
  a_r8_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_be_i == '0) |=> $stable(base_o));
endmodule

// File: rtl/bmdma_ctrl_regs.sv
module bmdma_ctrl_regs
  import bmdma_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned PTR_ALIGN = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic              req_dword_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic              eng_busy_i,
  input  logic              eng_err_i,
  input  logic              drv_irq_i,
  output logic              start_o,
  output logic              to_mem_o,
  output logic [DATA_W-1:0] table_base_o,
  output logic              xfer_good_o
);
  localparam int unsigned LANES     = DATA_W / 8;
  localparam int unsigned LANE_BITS = $clog2(LANES);
  localparam int unsigned REG_BYTES = 1 << ADDR_W;
  localparam int unsigned HI_W      = ADDR_W - LANE_BITS;

  logic                 aligned;
  logic [REG_BYTES-1:0] wr_byte;
  logic [7:0]           wbyte [REG_BYTES];
  logic [7:0]           img   [REG_BYTES];
  logic [7:0]           cmd_byte, stat_byte;
  logic [LANES-1:0]     ptr_be;
  logic [DATA_W-1:0]    ptr_wdata;
  logic [DATA_W-1:0]    rd_next;

  assign aligned = (req_addr_i[LANE_BITS-1:0] == '0);

  // per-byte write strobes and data for both access sizes
  for (genvar k = 0; k < REG_BYTES; k++) begin : g_wdec
    localparam int unsigned LANE = k % LANES;
    localparam logic [HI_W-1:0] HI = HI_W'(k / LANES);
    assign wr_byte[k] = req_valid_i & req_write_i &
                        (req_dword_i ? (aligned & (req_addr_i[ADDR_W-1:LANE_BITS] == HI))
                                     : (req_addr_i == ADDR_W'(k)));
    assign wbyte[k]   = req_dword_i ? req_wdata_i[8*LANE +: 8] : req_wdata_i[7:0];
  end

  for (genvar b = 0; b < LANES; b++) begin : g_ptr_lane
    assign ptr_be[b]          = wr_byte[OFS_PTR + b];
    assign ptr_wdata[8*b +: 8] = wbyte[OFS_PTR + b];
  end

  bmdma_cmd_reg u_cmd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_byte[OFS_CMD]),
    .wdata_i   (wbyte[OFS_CMD]),
    .run_o     (start_o),
    .to_mem_o  (to_mem_o),
    .rd_byte_o (cmd_byte)
  );

  bmdma_stat_reg u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_i        (wr_byte[OFS_STAT]),
    .wdata_i     (wbyte[OFS_STAT]),
    .busy_i      (eng_busy_i),
    .err_pulse_i (eng_err_i),
    .irq_line_i  (drv_irq_i),
    .rd_byte_o   (stat_byte),
    .good_o      (xfer_good_o)
  );

  bmdma_ptr_reg #(
    .PTR_W     (DATA_W),
    .PTR_ALIGN (PTR_ALIGN)
  ) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_be_i (ptr_be),
    .wdata_i (ptr_wdata),
    .base_o  (table_base_o)
  );

  // byte image of the register space; reserved offsets read 0
  always_comb begin
    for (int k = 0; k < REG_BYTES; k++) img[k] = '0;
    img[OFS_CMD]  = cmd_byte;
    img[OFS_STAT] = stat_byte;
    for (int b = 0; b < LANES; b++) img[OFS_PTR + b] = table_base_o[8*b +: 8];
  end

  always_comb begin
    rd_next = '0;
    if (req_dword_i) begin
      if (aligned) begin
        for (int b = 0; b < LANES; b++)
          rd_next[8*b +: 8] = img[req_addr_i | ADDR_W'(b)];
      end
    end else begin
      rd_next[7:0] = img[req_addr_i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsp_rdata_o <= '0;
    else if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_next;
  end

  // R11: unaligned dword read returns zero
  a_r11_unaligned_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && req_dword_i && !aligned) |=> (rsp_rdata_o == '0));
  // R11: read data holds between reads
  a_r11_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> $stable(rsp_rdata_o));
  // R9: byte writes to reserved offsets leave the command outputs alone
  a_r9_reserved_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_write_i && !req_dword_i && req_addr_i[0])
      |=> ($stable(start_o) && $stable(to_mem_o)));
endmodule

// File: tb/bmdma_ctrl_regs_tb.sv
module bmdma_ctrl_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_dword_i = 1'b0;
  logic [2:0]  req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] rsp_rdata_o;
  logic        eng_busy_i = 1'b0, eng_err_i = 1'b0, drv_irq_i = 1'b0;
  logic        start_o, to_mem_o, xfer_good_o;
  logic [31:0] table_base_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bmdma_ctrl_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_write_i(req_write_i), .req_dword_i(req_dword_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .rsp_rdata_o(rsp_rdata_o),
    .eng_busy_i(eng_busy_i), .eng_err_i(eng_err_i), .drv_irq_i(drv_irq_i),
    .start_o(start_o), .to_mem_o(to_mem_o), .table_base_o(table_base_o),
    .xfer_good_o(xfer_good_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic dw, input logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b1; req_dword_i = dw;
    req_addr_i = a; req_wdata_i = d;
    @(negedge clk);
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic dw, output logic [31:0] d);
    req_valid_i = 1'b1; req_write_i = 1'b0; req_dword_i = dw; req_addr_i = a;
    @(negedge clk);
    req_valid_i = 1'b0;
    d = rsp_rdata_o;
  endtask

  task automatic pulse_err();
    eng_err_i = 1'b1; @(negedge clk); eng_err_i = 1'b0;
  endtask

  task automatic irq_edge();
    drv_irq_i = 1'b0; @(negedge clk); drv_irq_i = 1'b1; @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  e;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", {31'b0, start_o}, 0);
    chk("R1 to_mem", {31'b0, to_mem_o}, 0);
    chk("R1 base", table_base_o, 0);
    chk("R1 good", {31'b0, xfer_good_o}, 0);
    chk("R1 rdata", rsp_rdata_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    rd(3'd2, 1'b0, r); chk("R1 status", r, 0);

    // R4 busy live, not writable
    eng_busy_i = 1'b1;
    rd(3'd2, 1'b0, r); chk("R4 busy high", r, 32'h1);
    eng_busy_i = 1'b0;
    wr(3'd2, 1'b0, 32'h01);
    rd(3'd2, 1'b0, r); chk("R4 write ignored", r, 32'h0);

    // R2 exhaustive command sweep
    for (int v = 0; v < 256; v++) begin
      wr(3'd0, 1'b0, 32'(v));
      chk("R2 start", {31'b0, start_o}, 32'(v & 1));
      chk("R2 to_mem", {31'b0, to_mem_o}, 32'((v >> 3) & 1));
      rd(3'd0, 1'b0, r); chk("R2 readback", r, 32'(v & 8'h09));
    end

    // R3 abort and hold
    wr(3'd0, 1'b0, 32'h09);
    eng_busy_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R3 hold", {31'b0, start_o}, 1);
    wr(3'd0, 1'b0, 32'h08);
    chk("R3 abort", {31'b0, start_o}, 0);
    chk("R3 dir kept", {31'b0, to_mem_o}, 1);
    eng_busy_i = 1'b0;

    // R5 R6 R7 R10 exhaustive status write sweep
    for (int v = 0; v < 256; v++) begin
      pulse_err();
      irq_edge();
      drv_irq_i = 1'b0;
      eng_busy_i = v[0];
      wr(3'd2, 1'b0, 32'(v));
      e = 8'h00;
      e[0] = v[0];
      e[1] = ~v[1];
      e[2] = ~v[2];
      e[5] = v[5];
      e[6] = v[6];
      rd(3'd2, 1'b0, r); chk("R5 R6 R7 status", r, {24'b0, e});
      chk("R10 good", {31'b0, xfer_good_o}, {31'b0, e[2:0] == 3'b100});
      wr(3'd2, 1'b0, 32'h06);
      eng_busy_i = 1'b0;
    end

    // R5 set wins over clear
    eng_err_i = 1'b1; wr(3'd2, 1'b0, 32'h02); eng_err_i = 1'b0;
    rd(3'd2, 1'b0, r); chk("R5 set wins", r & 32'h2, 32'h2);
    wr(3'd2, 1'b0, 32'h00);
    rd(3'd2, 1'b0, r); chk("R5 write0 keeps", r & 32'h2, 32'h2);
    wr(3'd2, 1'b0, 32'h02);
    rd(3'd2, 1'b0, r); chk("R5 cleared", r & 32'h2, 32'h0);

    // R6 held level does not re-set; set wins over clear
    irq_edge();
    wr(3'd2, 1'b0, 32'h04);
    repeat (3) @(negedge clk);
    rd(3'd2, 1'b0, r); chk("R6 level no reset", r & 32'h4, 32'h0);
    drv_irq_i = 1'b0; @(negedge clk);
    drv_irq_i = 1'b1; wr(3'd2, 1'b0, 32'h04);
    rd(3'd2, 1'b0, r); chk("R6 set wins", r & 32'h4, 32'h4);
    drv_irq_i = 1'b0;
    chk("R10 good idle", {31'b0, xfer_good_o}, 1);
    wr(3'd2, 1'b0, 32'h04);

    // R8 pointer patterns
    for (int p = 0; p < 32; p++) begin
      logic [31:0] d;
      d = (32'h9E37_79B9 * 32'(p + 1)) ^ (32'h1 << p);
      wr(3'd4, 1'b1, d);
      chk("R8 base", table_base_o, d & 32'hFFFF_FFFC);
      rd(3'd4, 1'b1, r); chk("R8 dword read", r, d & 32'hFFFF_FFFC);
    end
    wr(3'd4, 1'b1, 32'hFFFF_FFFF);
    chk("R8 align", table_base_o, 32'hFFFF_FFFC);
    for (int b = 0; b < 4; b++) begin
      logic [31:0] ex;
      wr(3'(4 + b), 1'b0, 32'h5A + 32'(b));
      ex = table_base_o;
      rd(3'(4 + b), 1'b0, r);
      chk("R8 byte read", r, {24'b0, ex[8*b +: 8]});
    end
    chk("R8 byte writes", table_base_o, 32'h5D5C_5B58);

    // R9 reserved offsets
    wr(3'd0, 1'b0, 32'h09);
    wr(3'd2, 1'b0, 32'h60);
    wr(3'd1, 1'b0, 32'hFF);
    wr(3'd3, 1'b0, 32'hFF);
    rd(3'd1, 1'b0, r); chk("R9 ofs1", r, 0);
    rd(3'd3, 1'b0, r); chk("R9 ofs3", r, 0);
    rd(3'd0, 1'b1, r); chk("R9 R11 dword0", r, 32'h0060_0009);

    // R11 unaligned dword and latency
    wr(3'd5, 1'b1, 32'h1234_5678);
    chk("R11 unaligned write", table_base_o, 32'h5D5C_5B58);
    rd(3'd6, 1'b1, r); chk("R11 unaligned read", r, 0);
    rd(3'd2, 1'b0, r); chk("R11 byte read", r, 32'h60);
    @(negedge clk);
    chk("R11 hold", rsp_rdata_o, 32'h60);

    finish_run();
  end
endmodule